// File: doc/BRIEF.md
# Hotplug Interrupt Classifier

This unit sits between the hotplug detect logic of a display transmitter and the interrupt controller of the host. It collects event pulses from several groups of sources into sticky status registers. Each status register has a mask register beside it, and software clears status bits by writing ones to them. One group carries the three hotplug sources: cable inserted, detect lost and detect changed. A top-level status register summarises each group. One output line carries the interrupt, and its assertion level is set in a control register.

Besides the line, the unit reports which hotplug event is pending, ranked by fixed priority, so the service routine can branch without decoding the raw bits. An insertion that newly becomes pending, with its mask enabled, also sends a one-cycle start request to the link bring-up sequencer. Removal and change events only need to be acknowledged. An initialise command clears the hotplug sources and the two detect-override bits of a small system control register in one write.

Top module: `hpd_irq_unit`

## Requirements
- R1: A one-cycle pulse on any bit of `src_evt` (bit g*8+k is bit k of group g) sets that status bit from the next cycle on. The bit stays set until it is cleared, and it reads back at address g.
- R2: A write to a group status address (0 to 3) clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged. Writing 8'hFF clears the whole group.
- R3: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R4: After reset the group masks at addresses 4 to 7 read 8'h00, 8'h00, 8'h00 and 8'h07. In group 3, bit 2 is cable-in, bit 1 is cable-out and bit 0 is change. The top mask at address 9 reads 8'h08, so bit 3, the hotplug summary, is its only enabled bit.
- R5: Bit g of the top status register (address 8) is the OR of group g's pending bits that are masked in. The register is read-only, so writes to it have no effect.
- R6: The interrupt is active when any top status bit is masked in, or when control bit 2 (soft interrupt) at address 10 is set. `irq_line` equals the active state when control bits 1 and 0 are both 1. Otherwise it is the inverse (active low). It follows a status change in the cycle after the edge that made the change.
- R7: `irq_kind` gives 0 (cable-in) when the group 3 bit 2 is pending. Otherwise it gives 1 (cable-out) if bit 1 is pending, otherwise 2 (change) if bit 0 is pending, otherwise 3 (unknown). The mask does not affect it.
- R8: `start_req` pulses high for exactly one cycle: the cycle after an edge at which group 3 bit 2 went from clear to pending while its mask bit was set. A cable-in event that arrives while the bit is already pending, or while it is masked out, gives no pulse.
- R9: A write to address 12 clears group 3 bits 2, 1 and 0, and clears bits 1 (`hpd_force`) and 0 (`hpd_ctrl`) of the system control register at address 11. All other bits keep their values.
- R10: During and after reset every status bit is 0, `irq_kind` is 3, `start_req` is 0, and `irq_line` is 1 (inactive at the default active-low setting).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| src_evt | input | 32 | Event pulses, 8 per group, 4 groups |
| irq_line | output | 1 | Interrupt line at the programmed level |
| irq_kind | output | 2 | Pending hotplug event kind |
| start_req | output | 1 | One-cycle link bring-up start request |
| hpd_force | output | 1 | Forced-detect bit of the system control register |
| hpd_ctrl | output | 1 | Detect-control bit of the system control register |

## Verification
Every register result appears one clock after the edge that captures the event or write: status bits, masks, the summary, the interrupt line, `irq_kind` and `start_req`. Read data is combinational from those registers. The bench drives stimulus just after a falling edge and lets one rising edge pass. It samples one time unit after the next falling edge, which is exactly the cycle in which each result is due. For the pulse-width part of R8, it samples again one cycle later to confirm the request has dropped.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;

   typedef enum logic [1:0] {
      HP_CABLE_IN  = 2'd0,
      HP_CABLE_OUT = 2'd1,
      HP_CHANGE    = 2'd2,
      HP_UNKNOWN   = 2'd3
   } hp_kind_e;

   // control register fields
   localparam int CTL_POL0 = 0;
   localparam int CTL_POL1 = 1;
   localparam int CTL_SOFT = 2;

   // system control register fields
   localparam int SYS_CTRL_BIT  = 0;
   localparam int SYS_FORCE_BIT = 1;

endpackage

// File: rtl/hpd_evt_group.sv
module hpd_evt_group #(
   parameter int           W       = 8,
   parameter logic [W-1:0] MSK_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr_we,
   input  logic         msk_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] init_clr,
   output logic [W-1:0] sta,
   output logic [W-1:0] msk,
   output logic         pend_any
);

   logic [W-1:0] clr_bits;

   always_comb begin
      clr_bits = init_clr;
      if (clr_we) clr_bits = clr_bits | wdata;
   end

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta <= '0;
      else        sta <= (sta & ~clr_bits) | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk <= MSK_RST;
      else if (msk_we) msk <= wdata;
   end

   assign pend_any = |(sta & msk);

endmodule

// File: rtl/hpd_classifier.sv
module hpd_classifier
   import hpd_irq_pkg::*;
#(
   parameter int W        = 8,
   parameter int PLUG_BIT = 2,
   parameter int LOST_BIT = 1,
   parameter int CHG_BIT  = 0
) (
   input  logic [W-1:0] sta,
   output hp_kind_e     kind
);

   always_comb begin
      if (sta[PLUG_BIT])      kind = HP_CABLE_IN;
      else if (sta[LOST_BIT]) kind = HP_CABLE_OUT;
      else if (sta[CHG_BIT])  kind = HP_CHANGE;
      else                    kind = HP_UNKNOWN;
   end

endmodule

// File: rtl/hpd_irq_line.sv
module hpd_irq_line
   import hpd_irq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] top_sta,
   input  logic [W-1:0] top_msk,
   input  logic [W-1:0] ctl,
   output logic         line
);

   logic active;
   logic pol_high;

   assign active   = (|(top_sta & top_msk)) | ctl[CTL_SOFT];
   assign pol_high = ctl[CTL_POL1] & ctl[CTL_POL0];
   assign line     = pol_high ? active : ~active;

endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
   import hpd_irq_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GRP_W      = 8,
   parameter int ADDR_W     = 4,
   parameter int HPD_GROUP  = 3,
   parameter int PLUG_BIT   = 2,
   parameter int LOST_BIT   = 1,
   parameter int CHG_BIT    = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [GRP_W-1:0]            reg_wdata,
   output logic [GRP_W-1:0]            reg_rdata,
   input  logic [NUM_GROUPS*GRP_W-1:0] src_evt,
   output logic                        irq_line,
   output logic [1:0]                  irq_kind,
   output logic                        start_req,
   output logic                        hpd_force,
   output logic                        hpd_ctrl
);

   localparam int A_STA_BASE = 0;
   localparam int A_MSK_BASE = NUM_GROUPS;
   localparam int A_TOP_STA  = 2 * NUM_GROUPS;
   localparam int A_TOP_MSK  = 2 * NUM_GROUPS + 1;
   localparam int A_CTL      = 2 * NUM_GROUPS + 2;
   localparam int A_SYS      = 2 * NUM_GROUPS + 3;
   localparam int A_INIT     = 2 * NUM_GROUPS + 4;
   localparam int PLUG_IDX   = HPD_GROUP * GRP_W + PLUG_BIT;

   localparam logic [GRP_W-1:0] HP_BITS =
      (GRP_W'(1) << PLUG_BIT) | (GRP_W'(1) << LOST_BIT) | (GRP_W'(1) << CHG_BIT);
   localparam logic [GRP_W-1:0] TOP_MSK_RST = GRP_W'(1) << HPD_GROUP;

   // elaboration-time parameter checks
   if (HPD_GROUP >= NUM_GROUPS) begin : g_bad_group
      $error("HPD_GROUP must select an existing group");
   end
   if (NUM_GROUPS > GRP_W) begin : g_bad_top
      $error("top status register cannot hold one bit per group");
   end
   if (A_INIT >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (PLUG_BIT >= GRP_W || LOST_BIT >= GRP_W || CHG_BIT >= GRP_W ||
       PLUG_BIT == LOST_BIT || PLUG_BIT == CHG_BIT || LOST_BIT == CHG_BIT) begin : g_bad_bits
      $error("hotplug source bits must be distinct and inside a group");
   end

   logic [NUM_GROUPS-1:0][GRP_W-1:0] grp_sta;
   logic [NUM_GROUPS-1:0][GRP_W-1:0] grp_msk;
   logic [NUM_GROUPS-1:0]            grp_pend;
   logic [GRP_W-1:0]                 top_sta;
   logic [GRP_W-1:0]                 top_msk;
   logic [GRP_W-1:0]                 ctl_q;
   logic [GRP_W-1:0]                 sys_q;
   logic                             init_hit;
   logic                             plug_rise;
   hp_kind_e                         kind;

   assign init_hit = reg_wr && (reg_addr == ADDR_W'(A_INIT));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam logic [GRP_W-1:0] MRST = (g == HPD_GROUP) ? HP_BITS : '0;
      logic [GRP_W-1:0] iclr;
      if (g == HPD_GROUP) begin : g_hp
         assign iclr = init_hit ? HP_BITS : '0;
      end else begin : g_plain
         assign iclr = '0;
      end
      hpd_evt_group #(
         .W       (GRP_W),
         .MSK_RST (MRST)
      ) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (src_evt[g*GRP_W +: GRP_W]),
         .clr_we   (reg_wr && (reg_addr == ADDR_W'(A_STA_BASE + g))),
         .msk_we   (reg_wr && (reg_addr == ADDR_W'(A_MSK_BASE + g))),
         .wdata    (reg_wdata),
         .init_clr (iclr),
         .sta      (grp_sta[g]),
         .msk      (grp_msk[g]),
         .pend_any (grp_pend[g])
      );
   end

   always_comb begin
      top_sta                 = '0;
      top_sta[NUM_GROUPS-1:0] = grp_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_msk <= TOP_MSK_RST;
         ctl_q   <= '0;
         sys_q   <= '0;
      end else begin
         if (reg_wr && reg_addr == ADDR_W'(A_TOP_MSK)) top_msk <= reg_wdata;
         if (reg_wr && reg_addr == ADDR_W'(A_CTL))     ctl_q   <= reg_wdata;
         if (reg_wr && reg_addr == ADDR_W'(A_SYS))     sys_q   <= reg_wdata;
         else if (init_hit) begin
            sys_q[SYS_CTRL_BIT]  <= 1'b0;
            sys_q[SYS_FORCE_BIT] <= 1'b0;
         end
      end
   end

   // start request on a fresh, masked-in cable-in event
   assign plug_rise = !grp_sta[HPD_GROUP][PLUG_BIT] &&
                      src_evt[PLUG_IDX] &&
                      grp_msk[HPD_GROUP][PLUG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_req <= 1'b0;
      else        start_req <= plug_rise;
   end

   hpd_classifier #(
      .W        (GRP_W),
      .PLUG_BIT (PLUG_BIT),
      .LOST_BIT (LOST_BIT),
      .CHG_BIT  (CHG_BIT)
   ) u_cls (
      .sta  (grp_sta[HPD_GROUP]),
      .kind (kind)
   );
   assign irq_kind = kind;

   hpd_irq_line #(
      .W (GRP_W)
   ) u_line (
      .top_sta (top_sta),
      .top_msk (top_msk),
      .ctl     (ctl_q),
      .line    (irq_line)
   );

   assign hpd_force = sys_q[SYS_FORCE_BIT];
   assign hpd_ctrl  = sys_q[SYS_CTRL_BIT];

   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (reg_addr == ADDR_W'(A_STA_BASE + g)) reg_rdata = grp_sta[g];
         if (reg_addr == ADDR_W'(A_MSK_BASE + g)) reg_rdata = grp_msk[g];
      end
      if (reg_addr == ADDR_W'(A_TOP_STA)) reg_rdata = top_sta;
      if (reg_addr == ADDR_W'(A_TOP_MSK)) reg_rdata = top_msk;
      if (reg_addr == ADDR_W'(A_CTL))     reg_rdata = ctl_q;
      if (reg_addr == ADDR_W'(A_SYS))     reg_rdata = sys_q;
   end

endmodule

// File: rtl/hpd_irq_unit_chk.sv
module hpd_irq_unit_chk #(
   parameter int NUM_GROUPS = 4,
   parameter int GRP_W      = 8,
   parameter int ADDR_W     = 4,
   parameter int HPD_GROUP  = 3,
   parameter int PLUG_BIT   = 2,
   parameter int LOST_BIT   = 1,
   parameter int CHG_BIT    = 0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_wr,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic [GRP_W-1:0]            reg_wdata,
   input logic [NUM_GROUPS*GRP_W-1:0] src_evt,
   input logic [NUM_GROUPS*GRP_W-1:0] sta_flat,
   input logic [1:0]                  irq_kind,
   input logic                        start_req
);

   localparam int BASE = HPD_GROUP * GRP_W;
   localparam int PI   = BASE + PLUG_BIT;
   localparam int LI   = BASE + LOST_BIT;
   localparam int CI   = BASE + CHG_BIT;

   // R1 and R3: an event always leaves its bit pending
   p_evt_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt != '0) |=> ((sta_flat & $past(src_evt)) == $past(src_evt)));

   // R1: without writes or events the status holds
   p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && src_evt == '0) |=> (sta_flat == $past(sta_flat)));

   p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(HPD_GROUP) && reg_wdata == '1 &&
       src_evt[BASE +: GRP_W] == '0) |=> (sta_flat[BASE +: GRP_W] == '0));

   p_kind_plug_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sta_flat[PI] |-> (irq_kind == 2'd0));

   p_kind_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sta_flat[PI] && sta_flat[LI]) |-> (irq_kind == 2'd1));

   p_kind_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sta_flat[PI] && !sta_flat[LI] && !sta_flat[CI]) |-> (irq_kind == 2'd3));

   p_start_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> !start_req);

   p_start_plug_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> sta_flat[PI]);

endmodule

bind hpd_irq_unit hpd_irq_unit_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .GRP_W      (GRP_W),
   .ADDR_W     (ADDR_W),
   .HPD_GROUP  (HPD_GROUP),
   .PLUG_BIT   (PLUG_BIT),
   .LOST_BIT   (LOST_BIT),
   .CHG_BIT    (CHG_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .src_evt   (src_evt),
   .sta_flat  (grp_sta),
   .irq_kind  (irq_kind),
   .start_req (start_req)
);

// File: tb/hpd_irq_unit_bench.sv
module hpd_irq_unit_bench;

   localparam int CLK_PERIOD = 10;

   localparam logic [31:0] E_CHG  = 32'h0100_0000;
   localparam logic [31:0] E_LOST = 32'h0200_0000;
   localparam logic [31:0] E_PLUG = 32'h0400_0000;
   localparam logic [31:0] E_B3   = 32'h0800_0000;

   typedef struct packed {
      logic        wr;
      logic [3:0]  addr;
      logic [7:0]  wdata;
      logic [31:0] evt;
      logic [7:0]  exp_sta;
      logic        exp_line;
      logic [1:0]  exp_kind;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 4'd3, 8'h00, E_PLUG,          8'h04, 1'b0, 2'd0},
      '{1'b0, 4'd3, 8'h00, E_LOST,          8'h06, 1'b0, 2'd0},
      '{1'b1, 4'd3, 8'h04, 32'h0,           8'h02, 1'b0, 2'd1},
      '{1'b1, 4'd3, 8'h02, E_CHG,           8'h01, 1'b0, 2'd2},
      '{1'b1, 4'd3, 8'hFF, 32'h0,           8'h00, 1'b1, 2'd3},
      '{1'b0, 4'd3, 8'h00, 32'h0000_0001,   8'h00, 1'b1, 2'd3},
      '{1'b0, 4'd3, 8'h00, E_B3,            8'h08, 1'b1, 2'd3},
      '{1'b1, 4'd3, 8'hFF, E_PLUG,          8'h04, 1'b0, 2'd0},
      '{1'b1, 4'd3, 8'hFF, 32'h0,           8'h00, 1'b1, 2'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic [31:0] src_evt = 32'd0;
   logic        irq_line;
   logic [1:0]  irq_kind;
   logic        start_req;
   logic        hpd_force;
   logic        hpd_ctrl;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hpd_irq_unit u_hpd_irq_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .src_evt   (src_evt),
      .irq_line  (irq_line),
      .irq_kind  (irq_kind),
      .start_req (start_req),
      .hpd_force (hpd_force),
      .hpd_ctrl  (hpd_ctrl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic cyc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic [31:0] e);
      reg_wr = wr; reg_addr = a; reg_wdata = d; src_evt = e;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; src_evt = 32'd0;
      #1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 line in reset", irq_line, 1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 line", irq_line, 1);
      chk("R10 kind", irq_kind, 3);
      chk("R10 start", start_req, 0);
      rd(4'd3, v); chk("R10 status3", v, 8'h00);
      rd(4'd4, v); chk("R4 mask0", v, 8'h00);
      rd(4'd5, v); chk("R4 mask1", v, 8'h00);
      rd(4'd6, v); chk("R4 mask2", v, 8'h00);
      rd(4'd7, v); chk("R4 mask3", v, 8'h07);
      rd(4'd9, v); chk("R4 top mask", v, 8'h08);
      rd(4'd8, v); chk("R5 top status reset", v, 8'h00);

      // vector table: R1 R2 R3 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         cyc(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].evt);
         rd(4'd3, v);
         chk($sformatf("R1/R2/R3 vec%0d status3", i), v, VEC[i].exp_sta);
         chk($sformatf("R6 vec%0d line", i), irq_line, VEC[i].exp_line);
         chk($sformatf("R7 vec%0d kind", i), irq_kind, VEC[i].exp_kind);
      end

      // group 0 bit 0 still pending from the table
      rd(4'd0, v); chk("R1 group0 sticky", v, 8'h01);
      rd(4'd8, v); chk("R5 top status group0 unmasked", v, 8'h00);
      cyc(1'b1, 4'd4, 8'h01, 32'd0);
      rd(4'd8, v); chk("R5 top status group0", v, 8'h01);
      chk("R6 top-masked line", irq_line, 1);
      cyc(1'b1, 4'd8, 8'hFF, 32'd0);
      rd(4'd8, v); chk("R5 read-only", v, 8'h01);
      cyc(1'b1, 4'd9, 8'h09, 32'd0);
      chk("R6 top unmask line", irq_line, 0);
      cyc(1'b1, 4'd0, 8'hFF, 32'd0);
      chk("R6 deassert after clear", irq_line, 1);
      rd(4'd8, v); chk("R2 group0 cleared", v, 8'h00);
      cyc(1'b1, 4'd9, 8'h08, 32'd0);

      // polarity and soft interrupt
      cyc(1'b1, 4'd10, 8'h03, 32'd0);
      chk("R6 active-high idle", irq_line, 0);
      cyc(1'b1, 4'd10, 8'h07, 32'd0);
      chk("R6 soft active-high", irq_line, 1);
      cyc(1'b1, 4'd10, 8'h04, 32'd0);
      chk("R6 soft active-low", irq_line, 0);
      cyc(1'b1, 4'd10, 8'h01, 32'd0);
      chk("R6 single pol bit idle", irq_line, 1);
      cyc(1'b1, 4'd10, 8'h00, 32'd0);

      // start request
      cyc(1'b0, 4'd3, 8'h00, E_PLUG);
      chk("R8 start pulse", start_req, 1);
      cyc(1'b0, 4'd3, 8'h00, 32'd0);
      chk("R8 start one cycle", start_req, 0);
      cyc(1'b0, 4'd3, 8'h00, E_PLUG);
      chk("R8 no start while pending", start_req, 0);
      cyc(1'b1, 4'd3, 8'hFF, 32'd0);
      cyc(1'b1, 4'd7, 8'h03, 32'd0);
      cyc(1'b0, 4'd3, 8'h00, E_PLUG);
      chk("R8 no start when masked", start_req, 0);
      chk("R7 kind ignores mask", irq_kind, 0);
      chk("R6 masked plug line", irq_line, 1);
      cyc(1'b1, 4'd3, 8'hFF, 32'd0);
      cyc(1'b1, 4'd7, 8'h07, 32'd0);

      // initialise command
      cyc(1'b1, 4'd11, 8'h83, 32'd0);
      chk("R9 force set", hpd_force, 1);
      chk("R9 ctrl set", hpd_ctrl, 1);
      cyc(1'b0, 4'd3, 8'h00, E_B3 | E_PLUG | E_LOST | E_CHG);
      rd(4'd3, v); chk("R9 pre-init status", v, 8'h0F);
      cyc(1'b1, 4'd12, 8'h00, 32'd0);
      rd(4'd3, v); chk("R9 init clears hotplug bits", v, 8'h08);
      chk("R9 force cleared", hpd_force, 0);
      chk("R9 ctrl cleared", hpd_ctrl, 0);
      rd(4'd11, v); chk("R9 other sys bits kept", v, 8'h80);
      chk("R7 kind after init", irq_kind, 3);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule